// File: doc/BRIEF.md
# Masked Status and Interrupt Register Bank

This block is the software-facing status side of a memory card host controller. It keeps a 22-bit status word made of two halves. The low 11 bits are sticky event flags that the command and data engines raise with one-cycle set pulses. The upper 11 bits are FIFO and activity levels that follow the data engine's level flags. Software clears events with a write-one-to-clear register. Two independent 32-bit mask registers each select which status bits drive one of two registered, level-sensitive interrupt lines.

The bank also serves the data path through a word-addressed bus. It returns the number of words still to move, derived from the engine's remaining byte count, and it decodes a FIFO data window. A FIFO data read that returns a word raises a refill hold-off flag. The flag stops the data engine from moving more data until software next reads the status register or the word-count register. This pacing suits drivers that cannot cope with the FIFO changing underneath them.

Top module: `mmc_status_bank`

## Requirements
- R1: After reset the status word, both mask registers, the hold-off flag and both interrupt lines are zero.
- R2: An `evt_set` pulse on bit k (k in 0..10) sets status bit k, and the bit stays set after the pulse until software clears it.
- R3: A bus write to word address 1 (clear) clears each status bit k in 0..10 whose write-data bit k is one. Status bits 11..21 are never changed by such a write, whatever the data.
- R4: When an `evt_set` pulse and a clear write hit the same event bit in the same cycle, the bit ends up set.
- R5: Interrupt line i is high exactly one clock after the cycle in which the status word ANDed with mask register i (status zero-extended to 32 bits) is nonzero. Mask 0 is at word address 2 and mask 1 at word address 3.
- R6: A read of word address 4 returns (`byte_cnt` + 3) >> 2, the remaining byte count rounded up to whole 32-bit words.
- R7: A read in the FIFO window (word addresses 16..31, top address bit set) while `fifo_empty` is low returns `fifo_rdata`, pulses `fifo_pop` in that bus cycle, and sets `refill_hold` from the next clock.
- R8: A read of the status register (word address 0) or the word-count register returns the current value in that bus cycle and clears `refill_hold` from the next clock.
- R9: A FIFO window read while `fifo_empty` is high returns zero, raises no `fifo_pop` and leaves `refill_hold` unchanged.
- R10: A FIFO window write while `byte_cnt` is zero raises no `fifo_push`. While `byte_cnt` is nonzero, it pulses `fifo_push` in that bus cycle with `fifo_wdata` equal to the write data.
- R11: Status bits 11..21 equal `lvl_flags` bits 0..10 of the previous clock.
- R12: Both mask registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| evt_set | input | 11 | Event set pulses from the engines |
| lvl_flags | input | 11 | FIFO and activity levels from the data engine |
| byte_cnt | input | 16 | Bytes still to transfer |
| fifo_empty | input | 1 | Data FIFO holds no word |
| fifo_rdata | input | 32 | Word at the FIFO head |
| fifo_pop | output | 1 | Remove the head word |
| fifo_push | output | 1 | Append `fifo_wdata` |
| fifo_wdata | output | 32 | Word to append |
| refill_hold | output | 1 | Data engine must not move data |
| irq | output | 2 | Level interrupt lines |

## Verification
On every cycle, assertions check several properties. Set pulses always survive into the status word, and events stay sticky without a clear. Clear writes leave the level half tracking its input. Each interrupt line matches the masked status of the previous cycle, and mask writes land. A pop always raises the hold-off, while a status or count read drops it. Pops and pushes never happen on an empty FIFO or a zero count. Only the bench scenarios can show the values software sees: the word-count rounding at its edges, the exact read data in the FIFO window, the one-cycle lag of the interrupts, and the clear register sparing the level bits when written with all ones.

// File: rtl/mmc_sb_pkg.sv
package mmc_sb_pkg;

    // Register selected by a bus address.
    typedef enum logic [2:0] {
        RS_NONE,
        RS_STATUS,
        RS_CLEAR,
        RS_MASK,
        RS_WCOUNT,
        RS_FIFO
    } reg_sel_e;

    localparam int unsigned STATUS_ADDR = 0;
    localparam int unsigned CLEAR_ADDR  = 1;
    localparam int unsigned MASK_BASE   = 2;

endpackage

// File: rtl/mmc_sb_decode.sv
module mmc_sb_decode
    import mmc_sb_pkg::*;
#(
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned NUM_IRQ = 2,
    parameter int unsigned IDX_W   = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  mask_idx
);

    localparam int unsigned WCOUNT_ADDR = MASK_BASE + NUM_IRQ;

    int unsigned a;

    always_comb begin
        a        = int'(addr);
        sel      = RS_NONE;
        mask_idx = '0;
        if (addr[ADDR_W-1]) begin
            sel = RS_FIFO;
        end else if (a == STATUS_ADDR) begin
            sel = RS_STATUS;
        end else if (a == CLEAR_ADDR) begin
            sel = RS_CLEAR;
        end else if (a >= MASK_BASE && a < MASK_BASE + NUM_IRQ) begin
            sel      = RS_MASK;
            mask_idx = IDX_W'(a - MASK_BASE);
        end else if (a == WCOUNT_ADDR) begin
            sel = RS_WCOUNT;
        end
    end

endmodule

// File: rtl/mmc_sb_status.sv
module mmc_sb_status #(
    parameter int unsigned EVT_W = 11,
    parameter int unsigned LVL_W = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [EVT_W-1:0]         evt_set,
    input  logic [LVL_W-1:0]         lvl_in,
    input  logic                     clr_stb,
    input  logic [EVT_W-1:0]         clr_bits,
    output logic [EVT_W+LVL_W-1:0]   status
);

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [EVT_W-1:0] evt;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // set pulses are OR-ed in after the clear, so a set wins
        st_d.evt = (st_q.evt & ~(clr_stb ? clr_bits : '0)) | evt_set;
        st_d.lvl = lvl_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q;

    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_set) |=> ((st_q.evt & $past(evt_set)) == $past(evt_set)));

    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_stb |=> ((st_q.evt & $past(st_q.evt)) == $past(st_q.evt)));

    a_r3_clear_spares_levels: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> (st_q.lvl == $past(lvl_in)));

endmodule

// File: rtl/mmc_sb_irq.sv
module mmc_sb_irq #(
    parameter int unsigned NUM_IRQ = 2,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned STAT_W  = 22,
    parameter int unsigned IDX_W   = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mask_we,
    input  logic [IDX_W-1:0]          mask_idx,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [STAT_W-1:0]         status,
    output logic [NUM_IRQ*DATA_W-1:0] mask_flat,
    output logic [NUM_IRQ-1:0]        irq
);

    typedef struct packed {
        logic [NUM_IRQ-1:0][DATA_W-1:0] mask;
        logic [NUM_IRQ-1:0]             irq;
    } irq_state_t;

    irq_state_t s_d, s_q;
    logic [DATA_W-1:0] stat_ext;

    assign stat_ext = DATA_W'(status);

    always_comb begin
        s_d = s_q;
        if (mask_we) s_d.mask[mask_idx] = wdata;
        for (int i = 0; i < NUM_IRQ; i++) begin
            s_d.irq[i] = |(stat_ext & s_q.mask[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mask_flat = s_q.mask;
    assign irq       = s_q.irq;

    generate
        for (genvar g = 0; g < NUM_IRQ; g++) begin : g_chk
            a_r5_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
                irq[g] == $past(|(stat_ext & s_q.mask[g])));
        end
    endgenerate

    a_r12_mask_written: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (s_q.mask[$past(mask_idx)] == $past(wdata)));

endmodule

// File: rtl/mmc_status_bank.sv
module mmc_status_bank
    import mmc_sb_pkg::*;
#(
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned EVT_W   = 11,
    parameter int unsigned LVL_W   = 11,
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned NUM_IRQ = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [EVT_W-1:0]   evt_set,
    input  logic [LVL_W-1:0]   lvl_flags,
    input  logic [CNT_W-1:0]   byte_cnt,
    input  logic               fifo_empty,
    input  logic [DATA_W-1:0]  fifo_rdata,
    output logic               fifo_pop,
    output logic               fifo_push,
    output logic [DATA_W-1:0]  fifo_wdata,
    output logic               refill_hold,
    output logic [NUM_IRQ-1:0] irq
);

    localparam int unsigned STAT_W = EVT_W + LVL_W;
    localparam int unsigned IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    typedef struct packed {
        logic hold;
    } top_state_t;

    reg_sel_e                  sel;
    logic [IDX_W-1:0]          mask_idx;
    logic [STAT_W-1:0]         status;
    logic [NUM_IRQ*DATA_W-1:0] mask_flat;
    logic                      rd_stb, wr_stb;
    logic [CNT_W-2:0]          words_left;
    logic [DATA_W-1:0]         mask_rd;
    top_state_t                t_d, t_q;

    assign rd_stb = bus_sel && !bus_wr;
    assign wr_stb = bus_sel &&  bus_wr;

    mmc_sb_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_IRQ (NUM_IRQ),
        .IDX_W   (IDX_W)
    ) i_decode (
        .addr     (bus_addr),
        .sel      (sel),
        .mask_idx (mask_idx)
    );

    mmc_sb_status #(
        .EVT_W (EVT_W),
        .LVL_W (LVL_W)
    ) i_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_set  (evt_set),
        .lvl_in   (lvl_flags),
        .clr_stb  (wr_stb && sel == RS_CLEAR),
        .clr_bits (bus_wdata[EVT_W-1:0]),
        .status   (status)
    );

    mmc_sb_irq #(
        .NUM_IRQ (NUM_IRQ),
        .DATA_W  (DATA_W),
        .STAT_W  (STAT_W),
        .IDX_W   (IDX_W)
    ) i_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_we   (wr_stb && sel == RS_MASK),
        .mask_idx  (mask_idx),
        .wdata     (bus_wdata),
        .status    (status),
        .mask_flat (mask_flat),
        .irq       (irq)
    );

    // rounded-up word count: whole words plus one for a partial word
    assign words_left = {1'b0, byte_cnt[CNT_W-1:2]} + (CNT_W-1)'(|byte_cnt[1:0]);

    always_comb begin
        mask_rd = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (int'(mask_idx) == i) mask_rd = mask_flat[i*DATA_W +: DATA_W];
        end
    end

    assign fifo_pop   = rd_stb && sel == RS_FIFO && !fifo_empty;
    assign fifo_push  = wr_stb && sel == RS_FIFO && byte_cnt != '0;
    assign fifo_wdata = bus_wdata;

    always_comb begin
        bus_rdata = '0;
        if (rd_stb) begin
            unique case (sel)
                RS_STATUS: bus_rdata = DATA_W'(status);
                RS_MASK:   bus_rdata = mask_rd;
                RS_WCOUNT: bus_rdata = DATA_W'(words_left);
                RS_FIFO:   bus_rdata = fifo_empty ? '0 : fifo_rdata;
                default:   bus_rdata = '0;
            endcase
        end
    end

    always_comb begin
        t_d = t_q;
        if (fifo_pop)
            t_d.hold = 1'b1;
        else if (rd_stb && (sel == RS_STATUS || sel == RS_WCOUNT))
            t_d.hold = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign refill_hold = t_q.hold;

    a_r7_pop_sets_hold: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> refill_hold);

    a_r8_read_releases_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (sel == RS_STATUS || sel == RS_WCOUNT)) |=> !refill_hold);

    a_r9_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> !fifo_pop);

    a_r10_no_push_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_cnt == '0) |-> !fifo_push);

endmodule

// File: tb/test_mmc_status_bank.sv
module test_mmc_status_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [10:0] evt_set = '0;
    logic [10:0] lvl_flags = '0;
    logic [15:0] byte_cnt = '0;
    logic        fifo_empty = 1'b1;
    logic [31:0] fifo_rdata = '0;
    logic        fifo_pop, fifo_push, refill_hold;
    logic [31:0] fifo_wdata;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mmc_status_bank i_mmc_status_bank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_set(evt_set), .lvl_flags(lvl_flags), .byte_cnt(byte_cnt),
        .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop),
        .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
        .refill_hold(refill_hold), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // read: rdata and pop sampled inside the access cycle
    task automatic bus_read(input logic [4:0] a, output logic [31:0] d, output logic pop);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata; pop = fifo_pop;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] v, output logic push,
                             output logic [31:0] pdata);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        #1 push = fifo_push; pdata = fifo_wdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic pulse(input logic [10:0] v);
        @(negedge clk); evt_set = v;
        @(negedge clk); evt_set = '0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        logic p; logic [31:0] pd;
        bus_write(a, v, p, pd);
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        logic p;
        bus_read(a, d, p);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 hold", 32'(refill_hold), 32'h0);
        rd(5'd0, d); chk("R1 status", d, 32'h0);
        rd(5'd2, d); chk("R1 mask0", d, 32'h0);
        rd(5'd3, d); chk("R1 mask1", d, 32'h0);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        pulse(11'h005);
        repeat (3) @(negedge clk);
        rd(5'd0, d); chk("R2 sticky events", d, 32'h005);
        pulse(11'h400);
        rd(5'd0, d); chk("R2 second event", d, 32'h405);
    endtask

    task automatic t_clear_levels();
        logic [31:0] d;
        @(negedge clk); lvl_flags = 11'h5A5;
        rd(5'd0, d); chk("R11 levels", d, {10'h0, 11'h5A5, 11'h405});
        pulse(11'h7FF);
        wr(5'd1, 32'h0000_000F);
        rd(5'd0, d); chk("R3 partial clear", d, {10'h0, 11'h5A5, 11'h7F0});
        wr(5'd1, 32'hFFFF_FFFF);
        rd(5'd0, d); chk("R3 levels survive clear", d, {10'h0, 11'h5A5, 11'h000});
        @(negedge clk); lvl_flags = 11'h000;
        rd(5'd0, d); chk("R11 levels drop", d, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        pulse(11'h030);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'd1; bus_wdata = 32'h030;
        evt_set = 11'h010;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; evt_set = '0;
        rd(5'd0, d); chk("R4 set wins over clear", d, 32'h010);
        wr(5'd1, 32'h7FF);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(5'd2, 32'h0000_0001);
        wr(5'd3, 32'h0000_1000);
        rd(5'd2, d); chk("R12 mask0 readback", d, 32'h0000_0001);
        rd(5'd3, d); chk("R12 mask1 readback", d, 32'h0000_1000);
        pulse(11'h001);
        #1 chk("R5 irq lags one cycle", 32'(irq), 32'h0);
        @(negedge clk); #1 chk("R5 irq0 raised", 32'(irq), 32'h1);
        pulse(11'h002);
        @(negedge clk); #1 chk("R5 unmasked bit no irq1", 32'(irq), 32'h1);
        @(negedge clk); lvl_flags = 11'h002;
        @(negedge clk); @(negedge clk); #1 chk("R5 irq1 from level bit 12", 32'(irq), 32'h3);
        wr(5'd1, 32'h1);
        @(negedge clk); #1 chk("R5 irq0 drops after clear", 32'(irq), 32'h2);
        @(negedge clk); lvl_flags = '0;
        wr(5'd1, 32'h7FF);
        @(negedge clk); @(negedge clk); #1 chk("R5 all low", 32'(irq), 32'h0);
    endtask

    task automatic t_wcount();
        logic [31:0] d;
        logic [15:0] cnts [5] = '{16'd0, 16'd1, 16'd4, 16'd5, 16'hFFFF};
        logic [31:0] exps [5] = '{32'd0, 32'd1, 32'd1, 32'd2, 32'h4000};
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); byte_cnt = cnts[i];
            rd(5'd4, d); chk("R6 word count", d, exps[i]);
        end
    endtask

    task automatic t_fifo_read();
        logic [31:0] d; logic p;
        @(negedge clk); fifo_empty = 1'b0; fifo_rdata = 32'hCAFE_0001;
        bus_read(5'd16, d, p);
        chk("R7 fifo data", d, 32'hCAFE_0001);
        chk("R7 pop pulse", 32'(p), 32'h1);
        #1 chk("R7 hold set", 32'(refill_hold), 32'h1);
        bus_read(5'd4, d, p);
        #1 chk("R8 hold cleared by count read", 32'(refill_hold), 32'h0);
        bus_read(5'd31, d, p);
        chk("R7 window top address", d, 32'hCAFE_0001);
        #1 chk("R7 hold set again", 32'(refill_hold), 32'h1);
        @(negedge clk); fifo_empty = 1'b1;
        bus_read(5'd20, d, p);
        chk("R9 empty read zero", d, 32'h0);
        chk("R9 no pop when empty", 32'(p), 32'h0);
        #1 chk("R9 hold unchanged", 32'(refill_hold), 32'h1);
        bus_read(5'd0, d, p);
        #1 chk("R8 hold cleared by status read", 32'(refill_hold), 32'h0);
        bus_read(5'd17, d, p);
        #1 chk("R9 empty read keeps hold low", 32'(refill_hold), 32'h0);
    endtask

    task automatic t_fifo_write();
        logic p; logic [31:0] pd;
        @(negedge clk); byte_cnt = 16'd0;
        bus_write(5'd18, 32'h1234_5678, p, pd);
        chk("R10 write ignored at zero count", 32'(p), 32'h0);
        @(negedge clk); byte_cnt = 16'd8;
        bus_write(5'd18, 32'h89AB_CDEF, p, pd);
        chk("R10 push pulse", 32'(p), 32'h1);
        chk("R10 push data", pd, 32'h89AB_CDEF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sticky();
        t_clear_levels();
        t_set_wins();
        t_irq();
        t_wcount();
        t_fifo_read();
        t_fifo_write();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule